// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes received Ethernet frames as a byte stream and stores them in a circular region of a 16-bit-word local buffer memory. The region is bounded by two page registers, a low page and a high page, where each page holds 256 bytes. Every stored frame gets an 8-byte header of four 16-bit words, followed by its payload padded to an even length. The header holds a completion event word, a status word, the byte address of the next header and the byte count. A host reads frames by walking these next-frame pointers.

The host owns a stop pointer. It sets this to the byte just before the oldest frame it has not yet consumed. The writer never writes the memory word that holds that byte. A frame that cannot fit in front of it is dropped as a whole: the base pointer stays where it was and an overrun pulse is raised. The header's event word is written last, so a poller never sees a frame that is only half stored.

Top module: `rxr_ring_writer`

## Requirements
- R1: During and right after a synchronous reset, `rx_base` equals `lim_lo`<<8, `in_ready` is 1, and `mem_we`, `frame_done` and `overrun` are 0.
- R2: Payload byte k of a frame whose header starts at byte address H is stored at byte H+8+k, with the ring wrap applied. The even byte goes in bits 7:0 of a word and the odd byte in bits 15:8. When the length is odd, the pad byte after the last payload byte is 0x00.
- R3: Header word H+2 (status) is 0x2000 for a frame that ends with `in_err` low. It is 0x0800 (good bit 13 clear, error bit 11 set) when `in_err` is high with the last byte.
- R4: Header word H+4 holds the next header's byte address, H+8+length rounded up to even, with the ring wrap applied. Header word H+6 holds the length in its low 14 bits, with bits 15:14 zero.
- R5: Header word H (event) is written with 0x0008 as the last write of a frame. This happens in the same cycle that `frame_done` pulses, and after the event word at the next header address has been written to 0x0000.
- R6: Byte addresses run from `lim_lo`<<8 up to (`lim_hi`<<8)|0xFF and then wrap to `lim_lo`<<8. The wrap also applies inside a frame's payload. No write falls outside this range.
- R7: No write ever lands on the word that contains byte `stop_ptr`. A frame is dropped when any of these words contains the stop byte: one of its four header words, one of its payload words, or the next header's event word. A dropped frame raises `overrun` for one cycle, does not pulse `frame_done`, and leaves `rx_base` and the event word at its header unchanged.
- R8: After the last byte of a stored frame is accepted, `in_ready` stays low for exactly 5 cycles. After a dropped frame, `in_ready` stays high.
- R9: `rx_base` moves to the new next-frame address in the cycle `frame_done` pulses, and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_data | input | 8 | Received frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 1 | Frame error, sampled with the final byte |
| in_ready | output | 1 | Writer can accept a byte |
| lim_lo | input | PAGE_BITS | First page of the ring |
| lim_hi | input | PAGE_BITS | Last page of the ring |
| stop_ptr | input | PAGE_BITS+OFF_BITS | Byte address the writer must not reach |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | PAGE_BITS+OFF_BITS-1 | Buffer memory word address |
| mem_wdata | output | 16 | Buffer memory write data |
| frame_done | output | 1 | One-cycle pulse when a frame is committed |
| overrun | output | 1 | One-cycle pulse when a frame is dropped |
| rx_base | output | PAGE_BITS+OFF_BITS | Byte address of the next header to be written |

## Verification
The bench builds the writer with PAGE_BITS=4, giving a 12-bit byte address, and keeps OFF_BITS=8 and LEN_BITS=14. The ring is limited to pages 2 and 3, a 512-byte region. This keeps the bench's model of the buffer small. It also means a short run of frames reaches the top of the ring, so one frame's payload wraps back to the low page. The stop pointer is placed a few bytes past the current header to reach each drop cause in turn: a header word, a payload word, and the next event word. A frame that ends one word short of the stop is accepted.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   // Header layout: four 16-bit words in front of each payload
   localparam int unsigned HDR_WORDS = 4;
   localparam int unsigned WORD_W    = 16;
   localparam int unsigned BYTE_W    = 8;

   // Fixed encodings the host relies on
   localparam logic [WORD_W-1:0] EVT_CODE  = 16'h0008;
   localparam int unsigned       GOOD_BIT  = 13;
   localparam logic [WORD_W-1:0] ERR_MASK  = 16'h0D81;

   typedef enum logic [2:0] {
      ST_RX   = 3'd0,
      ST_STAT = 3'd1,
      ST_NEXT = 3'd2,
      ST_CNT  = 3'd3,
      ST_CLR  = 3'd4,
      ST_EVT  = 3'd5
   } rxr_state_e;

endpackage

// File: rtl/rxr_ring_step.sv
module rxr_ring_step #(
   parameter  int PAGE_BITS = 8,
   parameter  int OFF_BITS  = 8,
   localparam int WW        = PAGE_BITS + OFF_BITS - 1,
   localparam int OW        = OFF_BITS - 1
) (
   input  logic [WW-1:0]        cur_w,
   input  logic [PAGE_BITS-1:0] lo_pg,
   input  logic [PAGE_BITS-1:0] hi_pg,
   output logic [WW-1:0]        nxt_w
);

   logic [WW-1:0] top_w;
   logic [WW-1:0] base_w;

   assign top_w  = {hi_pg, {OW{1'b1}}};
   assign base_w = {lo_pg, {OW{1'b0}}};
   assign nxt_w  = (cur_w == top_w) ? base_w : cur_w + 1'b1;

endmodule

// File: rtl/rxr_hdr_addr.sv
module rxr_hdr_addr
   import rxr_pkg::*;
#(
   parameter  int PAGE_BITS = 8,
   parameter  int OFF_BITS  = 8,
   localparam int WW        = PAGE_BITS + OFF_BITS - 1
) (
   input  logic [WW-1:0]                hdr_w,
   input  logic [PAGE_BITS-1:0]         lim_lo,
   input  logic [PAGE_BITS-1:0]         lim_hi,
   input  logic [WW-1:0]                stop_w,
   output logic [HDR_WORDS:0][WW-1:0]   hw,
   output logic                         hdr_hit
);

   logic [HDR_WORDS-1:0] hit_v;

   assign hw[0] = hdr_w;

   // Chain of ring steppers: hw[i] is header word i, hw[HDR_WORDS] is payload start
   for (genvar i = 0; i < HDR_WORDS; i++) begin : g_chain
      rxr_ring_step #(
         .PAGE_BITS(PAGE_BITS),
         .OFF_BITS (OFF_BITS)
      ) u_step (
         .cur_w(hw[i]),
         .lo_pg(lim_lo),
         .hi_pg(lim_hi),
         .nxt_w(hw[i+1])
      );
      assign hit_v[i] = (hw[i] == stop_w);
   end

   assign hdr_hit = |hit_v;

endmodule

// File: rtl/rxr_packer.sv
module rxr_packer
   import rxr_pkg::*;
#(
   parameter int LEN_BITS = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc,
   input  logic [BYTE_W-1:0]   byte_in,
   input  logic                last,
   output logic                emit,
   output logic [WORD_W-1:0]   word,
   output logic [LEN_BITS-1:0] len_nx,
   output logic                first
);

   logic                have_lo;
   logic [BYTE_W-1:0]   lo_q;
   logic [LEN_BITS-1:0] len_q;

   assign emit   = acc & (have_lo | last);
   assign word   = have_lo ? {byte_in, lo_q} : {{BYTE_W{1'b0}}, byte_in};
   assign len_nx = len_q + 1'b1;
   assign first  = (len_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_lo <= 1'b0;
         lo_q    <= '0;
         len_q   <= '0;
      end else if (acc) begin
         if (last) begin
            have_lo <= 1'b0;
            len_q   <= '0;
         end else begin
            len_q <= len_nx;
            if (have_lo) begin
               have_lo <= 1'b0;
            end else begin
               have_lo <= 1'b1;
               lo_q    <= byte_in;
            end
         end
      end
   end

   // R2: a byte held for pairing is consumed by the next accepted byte
   a_r2_pair_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && have_lo) |=> !have_lo);

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
   import rxr_pkg::*;
#(
   parameter  int PAGE_BITS = 8,
   parameter  int OFF_BITS  = 8,
   parameter  int LEN_BITS  = 14,
   parameter  int ERR_BIT   = 11,
   localparam int WW        = PAGE_BITS + OFF_BITS - 1,
   localparam int OW        = OFF_BITS - 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       in_last,
   input  logic                       in_err,
   output logic                       in_ready,
   input  logic [PAGE_BITS-1:0]       lim_lo,
   input  logic [PAGE_BITS-1:0]       lim_hi,
   input  logic [WW-1:0]              stop_w,
   input  logic                       emit,
   input  logic [WORD_W-1:0]          word,
   input  logic [LEN_BITS-1:0]        len_nx,
   input  logic                       first,
   input  logic [HDR_WORDS:0][WW-1:0] hw,
   input  logic                       hdr_hit,
   output logic [WW-1:0]              hdr_w,
   output logic                       acc,
   output logic                       mem_we,
   output logic [WW-1:0]              mem_addr,
   output logic [WORD_W-1:0]          mem_wdata,
   output logic                       frame_done,
   output logic                       overrun
);

   localparam logic [WORD_W-1:0] GOOD_WORD = WORD_W'(1) << GOOD_BIT;
   localparam logic [WORD_W-1:0] BAD_WORD  = WORD_W'(1) << ERR_BIT;

   rxr_state_e          state;
   logic [WW-1:0]       cur_w;
   logic                wrote_any;
   logic                drop;
   logic [WW-1:0]       nxt_w;
   logic [LEN_BITS-1:0] flen;
   logic                ferr;

   logic [WW-1:0]       wa;
   logic [WW-1:0]       wa_nx;
   logic [WW-1:0]       end_w;
   logic                drop_now;
   logic                ovr_now;
   logic                do_wr;

   logic                we_d;
   logic [WW-1:0]       a_d;
   logic [WORD_W-1:0]   d_d;

   assign in_ready = (state == ST_RX);
   assign acc      = in_valid & in_ready;

   // Next payload word: the payload start until the first word is written
   assign wa = wrote_any ? cur_w : hw[HDR_WORDS];

   rxr_ring_step #(
      .PAGE_BITS(PAGE_BITS),
      .OFF_BITS (OFF_BITS)
   ) u_wstep (
      .cur_w(wa),
      .lo_pg(lim_lo),
      .hi_pg(lim_hi),
      .nxt_w(wa_nx)
   );

   assign end_w    = emit ? wa_nx : wa;
   assign drop_now = drop | (acc & first & hdr_hit) | (emit & (wa == stop_w));
   assign ovr_now  = acc & in_last & (drop_now | (end_w == stop_w));
   assign do_wr    = emit & ~drop_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_RX;
         hdr_w     <= {lim_lo, {OW{1'b0}}};
         cur_w     <= '0;
         wrote_any <= 1'b0;
         drop      <= 1'b0;
         nxt_w     <= '0;
         flen      <= '0;
         ferr      <= 1'b0;
      end else begin
         unique case (state)
            ST_RX: begin
               if (acc) begin
                  if (emit) begin
                     cur_w     <= wa_nx;
                     wrote_any <= 1'b1;
                  end
                  if (in_last) begin
                     drop      <= 1'b0;
                     wrote_any <= 1'b0;
                     if (!ovr_now) begin
                        nxt_w <= end_w;
                        flen  <= len_nx;
                        ferr  <= in_err;
                        state <= ST_STAT;
                     end
                  end else begin
                     drop <= drop_now;
                  end
               end
            end
            ST_STAT: state <= ST_NEXT;
            ST_NEXT: state <= ST_CNT;
            ST_CNT:  state <= ST_CLR;
            ST_CLR:  state <= ST_EVT;
            ST_EVT: begin
               hdr_w <= nxt_w;
               state <= ST_RX;
            end
            default: state <= ST_RX;
         endcase
      end
   end

   // Write port source select, registered below
   always_comb begin
      we_d = 1'b0;
      a_d  = wa;
      d_d  = word;
      unique case (state)
         ST_RX:   we_d = do_wr;
         ST_STAT: begin we_d = 1'b1; a_d = hw[1]; d_d = ferr ? BAD_WORD : GOOD_WORD; end
         ST_NEXT: begin we_d = 1'b1; a_d = hw[2]; d_d = WORD_W'({nxt_w, 1'b0}); end
         ST_CNT:  begin we_d = 1'b1; a_d = hw[3]; d_d = WORD_W'(flen); end
         ST_CLR:  begin we_d = 1'b1; a_d = nxt_w; d_d = '0; end
         ST_EVT:  begin we_d = 1'b1; a_d = hw[0]; d_d = EVT_CODE; end
         default: we_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we     <= 1'b0;
         mem_addr   <= '0;
         mem_wdata  <= '0;
         frame_done <= 1'b0;
         overrun    <= 1'b0;
      end else begin
         mem_we     <= we_d;
         mem_addr   <= a_d;
         mem_wdata  <= d_d;
         frame_done <= (state == ST_EVT);
         overrun    <= ovr_now;
      end
   end

   // R8: the writer stops taking bytes only after a final byte was taken
   a_r8_hold_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> $past(in_valid && in_last));

   // R8: once a frame is committing, a further byte is refused next cycle
   a_r8_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && in_last && !ovr_now) |=> !in_ready);

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
   import rxr_pkg::*;
#(
   parameter  int PAGE_BITS = 8,
   parameter  int OFF_BITS  = 8,
   parameter  int LEN_BITS  = 14,
   parameter  int ERR_BIT   = 11,
   localparam int AW        = PAGE_BITS + OFF_BITS,
   localparam int WW        = AW - 1,
   localparam int OW        = OFF_BITS - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [7:0]           in_data,
   input  logic                 in_last,
   input  logic                 in_err,
   output logic                 in_ready,
   input  logic [PAGE_BITS-1:0] lim_lo,
   input  logic [PAGE_BITS-1:0] lim_hi,
   input  logic [AW-1:0]        stop_ptr,
   output logic                 mem_we,
   output logic [WW-1:0]        mem_addr,
   output logic [15:0]          mem_wdata,
   output logic                 frame_done,
   output logic                 overrun,
   output logic [AW-1:0]        rx_base
);

   // Elaboration-time parameter checks
   if (AW > WORD_W) begin : g_chk_aw
      $error("byte address must fit the next-frame word");
   end
   if (OFF_BITS < 4) begin : g_chk_off
      $error("page must hold at least one header plus a word");
   end
   if (LEN_BITS < 1 || LEN_BITS > 16) begin : g_chk_len
      $error("length field width out of range");
   end
   if (ERR_BIT < 0 || ERR_BIT > 15 || ERR_MASK[ERR_BIT % 16] != 1'b1 || ERR_BIT == GOOD_BIT) begin : g_chk_err
      $error("error bit must be one of the error-mask bits");
   end

   logic [WW-1:0]              stop_w;
   logic [WW-1:0]              hdr_w;
   logic [HDR_WORDS:0][WW-1:0] hw;
   logic                       hdr_hit;
   logic                       acc;
   logic                       emit;
   logic [WORD_W-1:0]          word;
   logic [LEN_BITS-1:0]        len_nx;
   logic                       first;
   logic                       unused_stop_lsb;

   assign stop_w          = stop_ptr[AW-1:1];
   assign unused_stop_lsb = stop_ptr[0];
   assign rx_base         = {hdr_w, 1'b0};

   rxr_hdr_addr #(
      .PAGE_BITS(PAGE_BITS),
      .OFF_BITS (OFF_BITS)
   ) u_hdr (
      .hdr_w  (hdr_w),
      .lim_lo (lim_lo),
      .lim_hi (lim_hi),
      .stop_w (stop_w),
      .hw     (hw),
      .hdr_hit(hdr_hit)
   );

   rxr_packer #(
      .LEN_BITS(LEN_BITS)
   ) u_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .acc    (acc),
      .byte_in(in_data),
      .last   (in_last),
      .emit   (emit),
      .word   (word),
      .len_nx (len_nx),
      .first  (first)
   );

   rxr_ctrl #(
      .PAGE_BITS(PAGE_BITS),
      .OFF_BITS (OFF_BITS),
      .LEN_BITS (LEN_BITS),
      .ERR_BIT  (ERR_BIT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .in_err    (in_err),
      .in_ready  (in_ready),
      .lim_lo    (lim_lo),
      .lim_hi    (lim_hi),
      .stop_w    (stop_w),
      .emit      (emit),
      .word      (word),
      .len_nx    (len_nx),
      .first     (first),
      .hw        (hw),
      .hdr_hit   (hdr_hit),
      .hdr_w     (hdr_w),
      .acc       (acc),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .frame_done(frame_done),
      .overrun   (overrun)
   );

   // R7: no write lands on the word holding the stop byte
   a_r7_stop_guard: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr != $past(stop_ptr[AW-1:1])));

   // R6: every write stays inside the ring
   a_r6_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ((mem_addr >= {$past(lim_lo), {OW{1'b0}}}) &&
                  (mem_addr <= {$past(lim_hi), {OW{1'b1}}})));

   // R5: the commit pulse coincides with the event-code write
   a_r5_event_last: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (mem_we && mem_wdata == EVT_CODE && mem_addr == $past(hdr_w)));

   // R7: a frame is either committed or dropped, never both
   a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_done && overrun));

   // R9: the base pointer moves only with a commit
   a_r9_base_moves: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_base) |-> frame_done);

endmodule

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;

   localparam int CLK_PERIOD = 10;
   localparam int PB  = 4;
   localparam int AW  = PB + 8;
   localparam int NW  = 1 << (AW - 1);
   localparam int RB  = 32'h200;   // ring base byte address (page 2)
   localparam int RSZ = 512;       // pages 2..3
   localparam int NV  = 7;
   // {length, error flag, seed}
   localparam logic [24:0] VEC [0:NV-1] = '{
      {16'd1,   1'b0, 8'h10},
      {16'd2,   1'b0, 8'h20},
      {16'd7,   1'b0, 8'h31},
      {16'd60,  1'b1, 8'h44},
      {16'd200, 1'b0, 8'h05},
      {16'd151, 1'b0, 8'h9A},
      {16'd120, 1'b0, 8'hC3}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_data = '0;
   logic          in_last = 1'b0;
   logic          in_err = 1'b0;
   logic          in_ready;
   logic [PB-1:0] lim_lo = 4'd2;
   logic [PB-1:0] lim_hi = 4'd3;
   logic [AW-1:0] stop_ptr = 12'h3FE;
   logic          mem_we;
   logic [AW-2:0] mem_addr;
   logic [15:0]   mem_wdata;
   logic          frame_done;
   logic          overrun;
   logic [AW-1:0] rx_base;

   logic [15:0]   mem [0:NW-1];
   int            total = 0;
   int            bad = 0;
   int            n_done = 0;
   int            n_ovr = 0;
   bit            finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxr_ring_writer #(.PAGE_BITS(PB)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
      .lim_lo(lim_lo), .lim_hi(lim_hi), .stop_ptr(stop_ptr),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .frame_done(frame_done), .overrun(overrun), .rx_base(rx_base)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (frame_done) n_done <= n_done + 1;
      if (overrun) n_ovr <= n_ovr + 1;
   end

   function automatic int radd(int a, int k);
      return RB + (((a - RB + k) % RSZ) + RSZ) % RSZ;
   endfunction

   function automatic int rdw(int a);
      return int'(mem[a >> 1]);
   endfunction

   function automatic int rdb(int a);
      logic [15:0] w;
      w = mem[a >> 1];
      return (a % 2 == 1) ? int'(w[15:8]) : int'(w[7:0]);
   endfunction

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_frame(int len, bit err, logic [7:0] seed);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         in_valid = 1'b1;
         in_data  = seed + 8'(i);
         in_last  = (i == len - 1);
         in_err   = err && (i == len - 1);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      in_err   = 1'b0;
   endtask

   // Frame expected to be stored at header hdr
   task automatic good_frame(int hdr, int len, bit err, logic [7:0] seed, output int nxt);
      int busy;
      int d0;
      int pay_bad;
      d0 = n_done;
      send_frame(len, err, seed);
      busy = 0;
      while (!in_ready && busy < 20) begin
         busy++;
         @(negedge clk);
      end
      @(negedge clk);
      nxt = radd(hdr, 8 + ((len + 1) / 2) * 2);
      check("R8 commit busy cycles", busy, 5);
      check("R5 frame_done pulse", n_done - d0, 1);
      check("R5 event word", rdw(hdr), 16'h0008);
      check("R3 status word", rdw(radd(hdr, 2)), err ? 16'h0800 : 16'h2000);
      check("R4 next pointer", rdw(radd(hdr, 4)), nxt);
      check("R4 byte count", rdw(radd(hdr, 6)), len & 16'h3FFF);
      check("R5 next event cleared", rdw(nxt), 0);
      check("R9 rx_base advanced", int'(rx_base), nxt);
      pay_bad = 0;
      for (int i = 0; i < len; i++)
         if (rdb(radd(hdr, 8 + i)) != int'(8'(seed + 8'(i)))) pay_bad++;
      check("R2 payload bytes", pay_bad, 0);
      if (len % 2 == 1) check("R2 pad byte", rdb(radd(hdr, 8 + len)), 0);
   endtask

   task automatic drop_frame(int hdr, int len, string tag);
      int o0;
      int d0;
      o0 = n_ovr;
      d0 = n_done;
      send_frame(len, 1'b0, 8'h77);
      check({tag, " R8 ready stays high"}, int'(in_ready), 1);
      @(negedge clk);
      @(negedge clk);
      check({tag, " R7 overrun pulse"}, n_ovr - o0, 1);
      check({tag, " R7 no frame_done"}, n_done - d0, 0);
      check({tag, " R7 rx_base held"}, int'(rx_base), hdr);
      check({tag, " R7 event word untouched"}, rdw(hdr), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int hdr;
      int nxt;
      for (int i = 0; i < NW; i++) mem[i] = 16'hA5A5;
      mem[RB >> 1] = 16'h0000;
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1 rx_base at reset", int'(rx_base), RB);
      check("R1 in_ready at reset", int'(in_ready), 1);
      check("R1 mem_we at reset", int'(mem_we), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rx_base after reset", int'(rx_base), RB);
      check("R1 no pulses after reset", int'(frame_done) + int'(overrun), 0);

      // Vector table: R2..R6, R8, R9; frame 7 wraps mid-payload (R6)
      hdr = RB;
      for (int v = 0; v < NV; v++) begin
         stop_ptr = AW'(radd(hdr, -1));
         good_frame(hdr, int'(VEC[v][24:9]), VEC[v][8], VEC[v][7:0], nxt);
         hdr = nxt;
      end
      check("R6 wrap landed at low page", hdr, 32'h258);

      // R7: payload word reaches the stop byte
      stop_ptr = AW'(radd(hdr, 20));
      drop_frame(hdr, 40, "payload");
      // R7: stop byte inside the header
      stop_ptr = AW'(radd(hdr, 5));
      drop_frame(hdr, 2, "header");
      // R7: next header event word holds the stop byte
      stop_ptr = AW'(radd(hdr, 13));
      drop_frame(hdr, 4, "next-event");
      // Boundary: one word shorter fits in front of the same stop (R7)
      good_frame(hdr, 2, 1'b0, 8'hE0, nxt);
      check("R7 boundary frame stored at restored header", nxt, radd(hdr, 10));

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule